// File: doc/BRIEF.md
# Vertical Microinstruction Decoder

This block turns one 8-bit vertically encoded microword into the control strobes of a small byte-wide stack-machine datapath. The two top bits of the word pick the class. When they read 00 or 01 the word is a byte move, when they read 10 it is a control operation, and when they read 11 it is a conditional skip. A move names one of eight bus sources and one of eight load destinations, and it carries a flag that says whether the low or the high byte of the transfer is meant.

The control class covers several operations:
- incrementing or decrementing one of four registers,
- switching the interrupt request gate on or off,
- a direct jump within the zero page of microcode,
- loading the ALU function,
- an indirect jump through the operand register.

All strobes and fields come out of one register stage. The interrupt gate is a flag held inside the block. The microcode store, the datapath registers and the ALU sit outside the block.

Top module: `mcode_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every strobe and field output is driven to zero after that edge, and `irq_en` is cleared, whatever `uword` holds.
- R2: For a word with bit 7 = 0, one cycle later `src_oe` is one-hot at the index given by bits 5..3, and `dst_ld` is one-hot at the index given by bits 2..0. `byte_hi` equals bit 6.
- R3: For a word with bit 7 = 1, one cycle later `src_oe`, `dst_ld` and `byte_hi` are all zero.
- R4: Word 100000rr sets `reg_dec[rr]` one cycle later, and word 100010rr sets `reg_inc[rr]` one cycle later. Only that one bit of the two vectors is set. Index 0 is W, 1 is IP, 2 is the parameter stack pointer and 3 is the return stack pointer.
- R5: Word 100011xx sets `irq_en` after the edge, and word 100001xx clears it after the edge. Every other word leaves `irq_en` unchanged.
- R6: Word 1001aaaa raises `jmp_direct` one cycle later, with `jmp_target` = aaaa. Otherwise `jmp_direct` is low and `jmp_target` is zero.
- R7: Word 1010ffff raises `alu_fn_ld` one cycle later, with `alu_fn` = ffff. Otherwise both are zero.
- R8: Word 1011xxxx raises `jmp_indirect` one cycle later, whatever the value of xxxx.
- R9: Word 11tttddd raises `skip_req` one cycle later, with `skip_test` = ttt and `skip_dist` = ddd. Otherwise all three are zero.
- R10: Each word raises exactly one operation class one cycle later. The classes are a move, an increment, a decrement, a direct jump, an indirect jump, an ALU function load and a skip. The exception is the two interrupt words, which raise none of these classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| uword | input | 8 | Microinstruction to decode |
| src_oe | output | 8 | One-hot bus source output enables |
| dst_ld | output | 8 | One-hot destination load strobes |
| byte_hi | output | 1 | Move addresses the high byte |
| reg_inc | output | 4 | One-hot register increment strobes |
| reg_dec | output | 4 | One-hot register decrement strobes |
| irq_en | output | 1 | Interrupt request gate flag |
| jmp_direct | output | 1 | Direct zero-page jump strobe |
| jmp_indirect | output | 1 | Jump through operand register strobe |
| jmp_target | output | 4 | Zero-page jump address |
| alu_fn_ld | output | 1 | ALU function load strobe |
| alu_fn | output | 4 | ALU function code |
| skip_req | output | 1 | Conditional skip strobe |
| skip_test | output | 3 | Skip condition selector |
| skip_dist | output | 3 | Skip distance |

## Verification
Every output, the `irq_en` flag included, becomes valid exactly one clock edge after the word is presented. The bench therefore changes `uword` on a falling edge and samples the outputs at the next falling edge, which lies half a period after the single rising edge that captures the word. The interrupt flag is then held over several unrelated words, and each of those words is checked one edge after it is applied. In this way a stray change shows up at the cycle where it happens. The exclusivity check walks all 256 codes with the same one-edge spacing.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int UW    = 8;
  localparam int FW    = 3;
  localparam int NSEL  = 1 << FW;
  localparam int RW    = 2;
  localparam int NREG  = 1 << RW;
  localparam int NW    = 4;
  localparam int TW    = 3;
  localparam int DW    = 3;

  typedef enum logic [1:0] {
    GRP_MISC = 2'b00,
    GRP_JDIR = 2'b01,
    GRP_ALU  = 2'b10,
    GRP_JIND = 2'b11
  } ctrl_grp_e;

  typedef struct packed {
    logic [NREG-1:0] inc;
    logic [NREG-1:0] dec;
    logic            irq_on;
    logic            irq_off;
    logic            jdir;
    logic            jind;
    logic            alu_ld;
    logic            skip;
  } ctrl_t;
endpackage

// File: rtl/mcd_onehot.sv
module mcd_onehot #(
  parameter int SEL_W = 3,
  localparam int N = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [N-1:0]     y
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign y[i] = en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/mcd_move_dec.sv
module mcd_move_dec
  import mcd_pkg::*;
(
  input  logic [UW-1:0]   uw,
  output logic [NSEL-1:0] src_oe,
  output logic [NSEL-1:0] dst_ld,
  output logic            byte_hi
);
  logic is_move;
  assign is_move = !uw[UW-1];
  assign byte_hi = is_move && uw[UW-2];

  mcd_onehot #(.SEL_W(FW)) u_src (
    .en (is_move),
    .sel(uw[2*FW-1:FW]),
    .y  (src_oe)
  );

  mcd_onehot #(.SEL_W(FW)) u_dst (
    .en (is_move),
    .sel(uw[FW-1:0]),
    .y  (dst_ld)
  );
endmodule

// File: rtl/mcd_ctrl_dec.sv
module mcd_ctrl_dec
  import mcd_pkg::*;
(
  input  logic [UW-1:0] uw,
  output ctrl_t         c,
  output logic [NW-1:0] nib,
  output logic [TW-1:0] stest,
  output logic [DW-1:0] sdist
);
  logic            is_ctrl;
  logic            is_misc;
  ctrl_grp_e       grp;
  logic [1:0]      sub;
  logic [NREG-1:0] inc_v;
  logic [NREG-1:0] dec_v;

  assign is_ctrl = (uw[UW-1:UW-2] == 2'b10);
  assign grp     = ctrl_grp_e'(uw[5:4]);
  assign is_misc = is_ctrl && (grp == GRP_MISC);
  assign sub     = uw[3:2];

  mcd_onehot #(.SEL_W(RW)) u_inc (
    .en (is_misc && (sub == 2'b10)),
    .sel(uw[RW-1:0]),
    .y  (inc_v)
  );

  mcd_onehot #(.SEL_W(RW)) u_dec (
    .en (is_misc && (sub == 2'b00)),
    .sel(uw[RW-1:0]),
    .y  (dec_v)
  );

  always_comb begin
    c         = '0;
    c.inc     = inc_v;
    c.dec     = dec_v;
    c.irq_on  = is_misc && (sub == 2'b11);
    c.irq_off = is_misc && (sub == 2'b01);
    c.jdir    = is_ctrl && (grp == GRP_JDIR);
    c.alu_ld  = is_ctrl && (grp == GRP_ALU);
    c.jind    = is_ctrl && (grp == GRP_JIND);
    c.skip    = (uw[UW-1:UW-2] == 2'b11);
  end

  assign nib   = uw[NW-1:0];
  assign stest = uw[TW+DW-1:DW];
  assign sdist = uw[DW-1:0];
endmodule

// File: rtl/mcode_decoder.sv
module mcode_decoder
  import mcd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [UW-1:0]   uword,
  output logic [NSEL-1:0] src_oe,
  output logic [NSEL-1:0] dst_ld,
  output logic            byte_hi,
  output logic [NREG-1:0] reg_inc,
  output logic [NREG-1:0] reg_dec,
  output logic            irq_en,
  output logic            jmp_direct,
  output logic            jmp_indirect,
  output logic [NW-1:0]   jmp_target,
  output logic            alu_fn_ld,
  output logic [NW-1:0]   alu_fn,
  output logic            skip_req,
  output logic [TW-1:0]   skip_test,
  output logic [DW-1:0]   skip_dist
);
  logic [NSEL-1:0] src_n, dst_n;
  logic            hi_n;
  ctrl_t           c_n;
  logic [NW-1:0]   nib_n;
  logic [TW-1:0]   test_n;
  logic [DW-1:0]   dist_n;

  mcd_move_dec u_move (
    .uw     (uword),
    .src_oe (src_n),
    .dst_ld (dst_n),
    .byte_hi(hi_n)
  );

  mcd_ctrl_dec u_ctrl (
    .uw   (uword),
    .c    (c_n),
    .nib  (nib_n),
    .stest(test_n),
    .sdist(dist_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_oe       <= '0;
      dst_ld       <= '0;
      byte_hi      <= 1'b0;
      reg_inc      <= '0;
      reg_dec      <= '0;
      jmp_direct   <= 1'b0;
      jmp_indirect <= 1'b0;
      jmp_target   <= '0;
      alu_fn_ld    <= 1'b0;
      alu_fn       <= '0;
      skip_req     <= 1'b0;
      skip_test    <= '0;
      skip_dist    <= '0;
    end else begin
      src_oe       <= src_n;
      dst_ld       <= dst_n;
      byte_hi      <= hi_n;
      reg_inc      <= c_n.inc;
      reg_dec      <= c_n.dec;
      jmp_direct   <= c_n.jdir;
      jmp_indirect <= c_n.jind;
      jmp_target   <= c_n.jdir ? nib_n : '0;
      alu_fn_ld    <= c_n.alu_ld;
      alu_fn       <= c_n.alu_ld ? nib_n : '0;
      skip_req     <= c_n.skip;
      skip_test    <= c_n.skip ? test_n : '0;
      skip_dist    <= c_n.skip ? dist_n : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            irq_en <= 1'b0;
    else if (c_n.irq_on)  irq_en <= 1'b1;
    else if (c_n.irq_off) irq_en <= 1'b0;
  end

  // R2: a move word yields one source and one destination
  a_r2_move_onehot: assert property (@(posedge clk) disable iff (rst)
    !uword[UW-1] |=> ($countones(src_oe) == 1) && ($countones(dst_ld) == 1));

  // R3: non-move words drive no bus enable
  a_r3_no_bus_ctrl: assert property (@(posedge clk) disable iff (rst)
    uword[UW-1] |=> (src_oe == '0) && (dst_ld == '0) && !byte_hi);

  // R4: decrement word selects one register and no increment
  a_r4_dec_single: assert property (@(posedge clk) disable iff (rst)
    (uword[UW-1:2] == 6'b100000) |=> ($countones(reg_dec) == 1) && (reg_inc == '0));

  // R5: enable word sets the flag
  a_r5_irq_set: assert property (@(posedge clk) disable iff (rst)
    (uword[UW-1:2] == 6'b100011) |=> irq_en);

  // R5: the flag only moves on the two interrupt words
  a_r5_irq_hold: assert property (@(posedge clk) disable iff (rst)
    !((uword[UW-1:4] == 4'b1000) && uword[2]) |=> $stable(irq_en));

  // R10: at most one operation class per cycle
  a_r10_one_class: assert property (@(posedge clk) disable iff (rst)
    $countones({|src_oe, |reg_inc, |reg_dec, jmp_direct, jmp_indirect,
                alu_fn_ld, skip_req}) <= 1);
endmodule

// File: tb/mcode_decoder_test.sv
`timescale 1ns/1ps
module mcode_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] uword = 8'h00;
  logic [7:0] src_oe, dst_ld;
  logic       byte_hi;
  logic [3:0] reg_inc, reg_dec;
  logic       irq_en, jmp_direct, jmp_indirect, alu_fn_ld, skip_req;
  logic [3:0] jmp_target, alu_fn;
  logic [2:0] skip_test, skip_dist;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mcode_decoder uut (
    .clk(clk), .rst(rst), .uword(uword),
    .src_oe(src_oe), .dst_ld(dst_ld), .byte_hi(byte_hi),
    .reg_inc(reg_inc), .reg_dec(reg_dec), .irq_en(irq_en),
    .jmp_direct(jmp_direct), .jmp_indirect(jmp_indirect),
    .jmp_target(jmp_target), .alu_fn_ld(alu_fn_ld), .alu_fn(alu_fn),
    .skip_req(skip_req), .skip_test(skip_test), .skip_dist(skip_dist)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (uword %b)", req, act, exp, uword);
    end
  endtask

  task automatic apply(logic [7:0] w);
    @(negedge clk) uword = w;
    @(negedge clk);
  endtask

  task automatic t_reset_zero;
    rst = 1'b1;
    @(negedge clk) uword = 8'b0011_1010;
    @(negedge clk);
    @(negedge clk);
    chk("R1 src_oe", 32'(src_oe), 0);
    chk("R1 dst_ld", 32'(dst_ld), 0);
    chk("R1 strobes", {reg_inc, reg_dec, jmp_direct, jmp_indirect, alu_fn_ld, skip_req, byte_hi}, 0);
    chk("R1 irq_en", 32'(irq_en), 0);
    rst = 1'b0;
  endtask

  task automatic t_moves;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 8; s++)
        for (int d = 0; d < 8; d++) begin
          apply({1'b0, 1'(b), 3'(s), 3'(d)});
          chk("R2 src_oe", 32'(src_oe), 32'(8'b1 << s));
          chk("R2 dst_ld", 32'(dst_ld), 32'(8'b1 << d));
          chk("R2 byte_hi", 32'(byte_hi), 32'(b));
        end
  endtask

  task automatic t_incdec;
    for (int r = 0; r < 4; r++) begin
      apply({6'b100000, 2'(r)});
      chk("R4 dec", 32'(reg_dec), 32'(4'b1 << r));
      chk("R4 no inc", 32'(reg_inc), 0);
      chk("R3 no src", 32'({src_oe, dst_ld, byte_hi}), 0);
      apply({6'b100010, 2'(r)});
      chk("R4 inc", 32'(reg_inc), 32'(4'b1 << r));
      chk("R4 no dec", 32'(reg_dec), 0);
    end
  endtask

  task automatic t_irq;
    apply(8'b1000_1110);
    chk("R5 set", 32'(irq_en), 1);
    apply(8'b0101_0011);
    chk("R5 hold move", 32'(irq_en), 1);
    apply(8'b1000_0001);
    chk("R5 hold dec", 32'(irq_en), 1);
    apply(8'b1101_1011);
    chk("R5 hold skip", 32'(irq_en), 1);
    apply(8'b1000_0110);
    chk("R5 clear", 32'(irq_en), 0);
    apply(8'b1000_1000);
    chk("R5 hold inc", 32'(irq_en), 0);
    apply(8'b1010_1111);
    chk("R5 hold alu", 32'(irq_en), 0);
    apply(8'b1000_1101);
    chk("R5 set again", 32'(irq_en), 1);
    chk("R10 irq word no class",
        {|src_oe, |reg_inc, |reg_dec, jmp_direct, jmp_indirect, alu_fn_ld, skip_req}, 0);
  endtask

  task automatic t_jumps;
    for (int a = 0; a < 16; a++) begin
      apply({4'b1001, 4'(a)});
      chk("R6 jmp_direct", 32'(jmp_direct), 1);
      chk("R6 target", 32'(jmp_target), 32'(a));
      chk("R8 no indirect", 32'(jmp_indirect), 0);
    end
    for (int x = 0; x < 16; x += 5) begin
      apply({4'b1011, 4'(x)});
      chk("R8 jmp_indirect", 32'(jmp_indirect), 1);
      chk("R6 no direct", 32'({jmp_direct, jmp_target}), 0);
    end
  endtask

  task automatic t_alu;
    for (int f = 0; f < 16; f++) begin
      apply({4'b1010, 4'(f)});
      chk("R7 alu_fn_ld", 32'(alu_fn_ld), 1);
      chk("R7 alu_fn", 32'(alu_fn), 32'(f));
    end
    apply(8'b1001_0110);
    chk("R7 idle fields", 32'({alu_fn_ld, alu_fn}), 0);
  endtask

  task automatic t_skip;
    for (int t = 0; t < 8; t++)
      for (int d = 0; d < 8; d += 3) begin
        apply({2'b11, 3'(t), 3'(d)});
        chk("R9 skip_req", 32'(skip_req), 1);
        chk("R9 skip_test", 32'(skip_test), 32'(t));
        chk("R9 skip_dist", 32'(skip_dist), 32'(d));
        chk("R3 no bus", 32'({src_oe, dst_ld}), 0);
      end
    apply(8'b0111_1111);
    chk("R9 idle fields", 32'({skip_req, skip_test, skip_dist}), 0);
  endtask

  task automatic t_exclusive;
    for (int w = 0; w < 256; w++) begin
      logic [7:0] v;
      int exp_n;
      v = 8'(w);
      exp_n = (v[7:2] == 6'b100001 || v[7:2] == 6'b100011) ? 0 : 1;
      apply(v);
      chk("R10 class count",
          32'($countones({|src_oe, |reg_inc, |reg_dec, jmp_direct, jmp_indirect,
                          alu_fn_ld, skip_req})), 32'(exp_n));
    end
  endtask

  task automatic t_reset_clears_irq;
    apply(8'b1000_1100);
    chk("R5 set before reset", 32'(irq_en), 1);
    t_reset_zero();
  endtask

  initial begin
    t_reset_zero();
    t_moves();
    t_incdec();
    t_irq();
    t_jumps();
    t_alu();
    t_skip();
    t_exclusive();
    t_reset_clears_irq();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule